// File: doc/BRIEF.md
# Retimed Systolic All-Pole Lattice Filter

This block is an all-pole (autoregressive) lattice filter made of cascaded stages. Each stage holds one reflection coefficient, and that coefficient drives two multiply-add units. One unit subtracts the scaled backward term from the forward signal. The other folds the new forward signal into the backward signal. In a direct build the forward signal passes through every stage in one cycle and then comes back through the backward chain, so the longest combinational path grows with the stage count.

Here every delay is doubled, so the filter takes a new sample only on every second clock. Cut-set retiming then moves half of each doubled backward delay onto the forward edge between neighbouring stages. Every stage boundary is now registered, and no combinational path holds more than the two multiply-add units of one stage, whatever the stage count. The idle slots between samples carry a second, zero-valued stream that never touches the real one. A valid bit travels alongside the data, so the output strobe marks only real result slots.

Data and coefficients are 16-bit signed Q1.15 values. The stage count is a parameter, with at least two stages. Coefficients are static inputs, and the block does not compute them or check them for stability.

Top module: `lat_ar_systolic`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears all state. After such an edge `out_valid` is 0 and `out_sample` is 0.
- R2: `out_sample` follows the all-pole lattice recurrence. f_N = x[n]. For stages s = N down to 1, f_{s-1} = f_s - mul(k_s, g_{s-1}[n-1]) and g_s = g_{s-1}[n-1] + mul(k_s, f_{s-1}). Also g_0 = f_0, and y[n] = f_0. Here mul(a,b) is bits [30:15] of the 32-bit signed product, and stage s takes its coefficient from `coef` bits [16s-1:16(s-1)].
- R3: A sample taken at rising edge e shows on the ports after edge e+STAGES, with `out_valid` high for exactly that one cycle.
- R4: Input slots alternate with the rising edges. The first edge at which `rst` is low is an open slot, the next is closed, and so on. `in_valid` at a closed edge is ignored: it gives no output and leaves the filter state unchanged.
- R5: An open edge with `in_valid` low advances the filter by one sample with input 0 and gives no `out_valid`.
- R6: `out_sample` keeps its last value in every cycle where `out_valid` is low.
- R7: `out_valid` is never high in two consecutive cycles.
- R8: Every subtraction and addition wraps modulo 2^16 on overflow, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, taken only in open slots |
| in_sample | input | 16 | Input sample, signed Q1.15 |
| coef | input | 16*STAGES | Reflection coefficients, stage s in bits [16s-1:16(s-1)], signed Q1.15 |
| out_valid | output | 1 | High for one cycle when a real result is presented |
| out_sample | output | 16 | Filter output, signed Q1.15, held between results |

## Verification
The bench builds the block with its defaults: three stages and 16-bit data. At that size a cycle-by-cycle behavioural model of the unretimed lattice is cheap to run. The bench sweeps all eight sign patterns of the three coefficients over three input schedules: full rate, junk strobes in the closed slots, and open slots left empty. Every output edge is compared against the model for both strobe timing and value. A further run with coefficients at plus and minus full scale and full-scale inputs drives the sums into wraparound.

// File: rtl/lat_pkg.sv
package lat_pkg;

    localparam int unsigned DW   = 16;
    localparam int unsigned FRAC = DW - 1;

    typedef logic signed [DW-1:0]   smp_t;
    typedef logic signed [2*DW-1:0] prod_t;

    // sample token: data word with its slot strobe
    typedef struct packed {
        logic vld;
        smp_t val;
    } tok_t;

    // Q1.15 product truncated back to one word
    function automatic smp_t q_mul(input smp_t a, input smp_t b);
        prod_t p;
        p = a * b;
        return p[FRAC+DW-1:FRAC];
    endfunction

endpackage

// File: rtl/lat_fwd_mac.sv
module lat_fwd_mac
    import lat_pkg::*;
(
    input  smp_t f_in,
    input  smp_t g_dly,
    input  smp_t k,
    output smp_t f_out
);
    // forward path: remove the reflected backward contribution
    assign f_out = f_in - q_mul(k, g_dly);
endmodule

// File: rtl/lat_bwd_mac.sv
module lat_bwd_mac
    import lat_pkg::*;
(
    input  smp_t f_cur,
    input  smp_t g_dly,
    input  smp_t k,
    output smp_t g_out
);
    // backward path: add the reflected forward contribution
    assign g_out = g_dly + q_mul(k, f_cur);
endmodule

// File: rtl/lat_pace.sv
module lat_pace #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic accept,
    output logic open_slot,
    output logic load_en,
    output logic out_valid
);
    localparam logic OUT_PAR = 1'(STAGES % 2);

    logic              open_q;
    logic [STAGES:0]   vpipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b1;
            vpipe  <= '0;
        end else begin
            open_q <= ~open_q;
            vpipe  <= {vpipe[STAGES-1:0], accept};
        end
    end

    assign open_slot = open_q;
    assign accept    = in_valid & open_q;
    assign load_en   = vpipe[STAGES-1];
    assign out_valid = vpipe[STAGES];

    // R7: results are spaced by at least one idle cycle
    assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid)
        else $error("out_valid high in consecutive cycles");

    // R3: results land only on the slot parity fixed by the stage count
    assert_slot_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (open_q == OUT_PAR))
        else $error("out_valid on wrong slot parity");
endmodule

// File: rtl/lat_ar_systolic.sv
module lat_ar_systolic
    import lat_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DW-1:0]           in_sample,
    input  logic [STAGES*DW-1:0]    coef,
    output logic                    out_valid,
    output logic [DW-1:0]           out_sample
);
    localparam logic REAL_PAR = 1'((STAGES - 1) % 2);

    logic accept, open_slot, load_en;
    tok_t cap;
    smp_t gz;
    smp_t out_q;

    smp_t fa [1:STAGES];      // forward result of each stage (combinational)
    smp_t fq [2:STAGES];      // registered forward edge into the next stage
    smp_t gb [1:STAGES-1];    // backward result of each stage (combinational)
    smp_t gq [1:STAGES];      // single backward delay left after retiming

    lat_pace #(.STAGES(STAGES)) u_pace (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .accept    (accept),
        .open_slot (open_slot),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    // input capture: closed or empty slots inject zero
    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else begin
            cap.vld <= accept;
            cap.val <= accept ? smp_t'(in_sample) : '0;
        end
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        smp_t k_s;
        smp_t f_src;
        assign k_s = smp_t'(coef[(s-1)*DW +: DW]);

        if (s == STAGES) begin : g_top
            assign f_src = cap.val;
        end else begin : g_mid
            assign f_src = fq[s+1];
        end

        lat_fwd_mac u_fwd (
            .f_in  (f_src),
            .g_dly (gq[s]),
            .k     (k_s),
            .f_out (fa[s])
        );

        if (s < STAGES) begin : g_back
            lat_bwd_mac u_bwd (
                .f_cur (fa[s]),
                .g_dly (gq[s]),
                .k     (k_s),
                .g_out (gb[s])
            );
        end
    end

    // retimed delays: one D on each forward edge, one D on each backward
    // edge, and the full 2D on the output return into stage 1
    always_ff @(posedge clk) begin
        if (rst) begin
            gz    <= '0;
            out_q <= '0;
            for (int s = 1; s <= STAGES; s++) gq[s] <= '0;
            for (int s = 2; s <= STAGES; s++) fq[s] <= '0;
        end else begin
            gz    <= fa[1];
            gq[1] <= gz;
            for (int s = 2; s <= STAGES; s++) begin
                gq[s] <= gb[s-1];
                fq[s] <= fa[s];
            end
            if (load_en) out_q <= fa[1];
        end
    end

    assign out_sample = out_q;

    // R6: the output word moves only when a result is flagged
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample))
        else $error("output changed without out_valid");

    // R4: the idle interleaved stream stays zero at the last stage
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (open_slot != REAL_PAR) |-> (fa[1] == '0))
        else $error("idle slot stream is not zero");
endmodule

// File: tb/sim_lat_ar_systolic.sv
`timescale 1ns/1ps
module sim_lat_ar_systolic;
    localparam int N = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [15:0]        in_sample = '0;
    logic [N*16-1:0]    coef = '0;
    logic               out_valid;
    logic [15:0]        out_sample;

    always #2.5 clk = ~clk;

    lat_ar_systolic #(.STAGES(N)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef(coef), .out_valid(out_valid), .out_sample(out_sample)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic signed [15:0] kc [1:N];
    logic signed [15:0] gp [0:N-1];
    int                 q_edge [0:255];
    logic [15:0]        q_val  [0:255];
    int qh, qt, ed;
    logic [15:0] last_y;
    logic        prev_ov;
    logic [15:0] lf = 16'hACE1;
    string cur_req = "R2";

    function automatic logic signed [15:0] qm(input logic signed [15:0] a,
                                               input logic signed [15:0] b);
        logic signed [31:0] p;
        p = a * b;
        return p[30:15];
    endfunction

    // one sample of the unretimed lattice (R2 / R8 arithmetic)
    function automatic logic signed [15:0] advance(input logic signed [15:0] x);
        logic signed [15:0] f;
        logic signed [15:0] gn [0:N-1];
        f = x;
        for (int s = N; s >= 1; s--) begin
            f = f - qm(kc[s], gp[s-1]);
            if (s < N) gn[s] = gp[s-1] + qm(kc[s], f);
        end
        gn[0] = f;
        for (int i = 0; i < N; i++) gp[i] = gn[i];
        return f;
    endfunction

    task automatic fail(input string req, input logic [15:0] act, input logic [15:0] exp);
        nfail++;
        $display("FAIL %s edge=%0d actual=%h expected=%h", req, ed, act, exp);
    endtask

    task automatic load_coef();
        for (int s = 1; s <= N; s++) coef[(s-1)*16 +: 16] = kc[s];
    endtask

    // reset: entered and left just after a falling edge
    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_sample = '0;
        repeat (3) @(posedge clk);
        #1;
        nchk++; if (out_valid !== 1'b0) fail("R1", 16'(out_valid), 16'h0);
        nchk++; if (out_sample !== 16'h0) fail("R1", out_sample, 16'h0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) gp[i] = '0;
        qh = 0; qt = 0; ed = 0; last_y = '0; prev_ov = 1'b0;
    endtask

    task automatic step(input logic v, input logic [15:0] x);
        logic signed [15:0] ye;
        logic exp_v;
        in_valid = v; in_sample = x;
        @(posedge clk);
        if (ed % 2 == 0) begin
            ye = advance(v ? $signed(x) : 16'sd0);
            if (v) begin q_edge[qt] = ed + N; q_val[qt] = ye; qt++; end
        end
        #1;
        exp_v = (qh != qt) && (q_edge[qh] == ed);
        nchk++;
        if (out_valid !== exp_v) fail("R3", 16'(out_valid), 16'(exp_v));
        if (exp_v) begin
            nchk++;
            if (out_sample !== q_val[qh]) fail(cur_req, out_sample, q_val[qh]);
            last_y = q_val[qh];
            qh++;
        end else begin
            nchk++;
            if (out_sample !== last_y) fail("R6", out_sample, last_y);
        end
        nchk++;
        if (out_valid && prev_ov) fail("R7", 16'h1, 16'h0);
        prev_ov = out_valid;
        ed++;
        @(negedge clk);
    endtask

    function automatic logic [15:0] nextx(input int shamt);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return 16'($signed(lf) >>> shamt);
    endfunction

    // mode 0: full rate; 1: junk strobes in closed slots (R4); 2: empty open slots (R5)
    task automatic run(input int mode, input int nsmp, input int shamt);
        for (int j = 0; j < nsmp; j++) begin
            if (mode == 2 && (j % 3 == 2)) step(1'b0, nextx(shamt));
            else step(1'b1, nextx(shamt));
            if (mode == 1) step(1'b1, 16'h7FFF ^ 16'(j));
            else step(1'b0, 16'h5555);
        end
        for (int j = 0; j < 2 * N + 2; j++) step(1'b0, 16'h0);
        nchk++;
        if (qh != qt) fail(cur_req, 16'(qh), 16'(qt));
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // sweep all coefficient sign patterns over three input schedules
        for (int cs = 0; cs < 8; cs++) begin
            kc[1] = cs[0] ? -16'sh5000 : 16'sh5000;
            kc[2] = cs[1] ? -16'sh3000 : 16'sh3000;
            kc[3] = cs[2] ? -16'sh6800 : 16'sh6800;
            load_coef();
            for (int m = 0; m < 3; m++) begin
                cur_req = (m == 0) ? "R2" : (m == 1) ? "R4" : "R5";
                do_reset();
                run(m, 30, 1 + (cs % 3));
            end
        end
        // R2: impulse response
        cur_req = "R2";
        kc[1] = 16'sh4000; kc[2] = -16'sh2000; kc[3] = 16'sh6000;
        load_coef();
        do_reset();
        step(1'b1, 16'h4000); step(1'b0, 16'h0);
        for (int j = 0; j < 12; j++) begin step(1'b1, 16'h0); step(1'b0, 16'h0); end
        for (int j = 0; j < 2 * N + 2; j++) step(1'b0, 16'h0);
        // R8: full-scale coefficients and inputs force wraparound
        cur_req = "R8";
        kc[1] = 16'sh7FFF; kc[2] = 16'sh8000; kc[3] = 16'sh7FFF;
        load_coef();
        do_reset();
        for (int j = 0; j < 40; j++) begin
            step(1'b1, (j % 2 == 0) ? 16'h7FFF : 16'h8001);
            step(1'b0, 16'h0);
        end
        for (int j = 0; j < 2 * N + 2; j++) step(1'b0, 16'h0);
        do_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule